// File: doc/BRIEF.md
# Pipelined Modulo-3 Reduction Unit

This block returns the remainder of an unsigned 16-bit word divided by three. It uses no divider. It first estimates the quotient by multiplying the operand by a fixed-point approximation of one third. It then rebuilds three times that estimate from a shift and a single add, and subtracts the result from the operand. A final step folds any leftover multiple of three back into the range 0 to 2.

The work is spread over three register stages, so the block accepts one operand on every clock and hands back one remainder on every clock. A qualifier bit travels alongside each operand. The unit suits per-pixel or per-sample datapaths where a mod-3 value is needed at full clock rate and a divider would not meet timing.

Top module: `mod3_pipe`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the rising edge exactly three edges earlier, provided reset was low at that edge and at every edge since.
- R2: When `out_valid` is 1, `out_rem` equals the operand's remainder modulo 3, given as the plain binary values 0, 1 or 2. This holds for every one of the 65536 possible operands.
- R3: When `out_valid` is 1, `out_rem` never shows the code 3.
- R4: The uncorrected difference between the operand and three times the quotient estimate always lies between 0 and 5.
- R5: The correction stage subtracts 3 from the uncorrected difference when that difference is 3 or more. Otherwise it passes the difference through unchanged.
- R6: After a rising edge with reset high, `out_valid` is 0.
- R7: Operands may arrive on consecutive cycles with no idle cycles between them. Results then leave on consecutive cycles, in the order the operands arrived, with no stall.
- R8: Operands still inside the pipeline when reset is raised are discarded. No `out_valid` pulse appears for them after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the qualifier bits |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 16 | Unsigned operand |
| out_valid | output | 1 | Result qualifier |
| out_rem | output | 2 | Remainder modulo 3 |

## Verification
Every 16-bit operand is streamed once, back to back and in ascending order. This is the only way to show that the approximate reciprocal never leaves a quotient error the correction step cannot absorb. It also shows that full-rate streaming keeps the right order.

Small operands with idle gaps between them separate the qualifier path from the data path. Descending operands near the top of the range, alternating with idle cycles, exercise the largest estimate error. A reset raised while operands are in flight shows that those operands are dropped rather than delivered late.

// File: rtl/mod3_pkg.sv
package mod3_pkg;

  // Width of the low slice kept from the quotient and the operand.
  localparam int unsigned LO_W    = 3;
  // Largest uncorrected difference the reciprocal estimate can leave.
  localparam int unsigned RAW_MAX = 5;
  localparam int unsigned MODULUS = 3;

  typedef logic [LO_W-1:0] lo_t;
  typedef logic [1:0]      rem_t;

  // Low bits of 3*q, formed as q + 2q (shift and one add).
  function automatic lo_t triple_lo(input lo_t q_lo);
    lo_t twice;
    twice = {q_lo[LO_W-2:0], 1'b0};
    return q_lo + twice;
  endfunction

  // Low bits of x - 3q. Exact because the true difference is below 8.
  function automatic lo_t diff_lo(input lo_t x_lo, input lo_t t_lo);
    return x_lo - t_lo;
  endfunction

  // Fold a difference in 0..5 into 0..2.
  function automatic rem_t fold_raw(input lo_t raw);
    lo_t adj;
    if (raw >= lo_t'(MODULUS)) adj = raw - lo_t'(MODULUS);
    else                       adj = raw;
    return adj[1:0];
  endfunction

endpackage

// File: rtl/mod3_recip_stage.sv
module mod3_recip_stage
  import mod3_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              s1_valid,
  output lo_t               s1_qlo,
  output lo_t               s1_xlo
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam longint unsigned ONES = (64'd1 << DATA_W) - 64'd1;
  localparam logic [DATA_W-1:0] RECIP = DATA_W'(ONES / 64'd3);

  logic [PROD_W-1:0] prod;
  lo_t               q_est_lo;

  always_comb begin
    prod     = PROD_W'(in_data) * PROD_W'(RECIP);
    q_est_lo = prod[DATA_W +: LO_W];
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_qlo <= q_est_lo;
    s1_xlo <= in_data[LO_W-1:0];
  end

endmodule

// File: rtl/mod3_sub_stage.sv
module mod3_sub_stage
  import mod3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s1_valid,
  input  lo_t  s1_qlo,
  input  lo_t  s1_xlo,
  output logic s2_valid,
  output lo_t  s2_raw
);

  lo_t triple;
  lo_t raw_next;

  always_comb begin
    triple   = triple_lo(s1_qlo);
    raw_next = diff_lo(s1_xlo, triple);
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    s2_raw <= raw_next;
  end

endmodule

// File: rtl/mod3_fix_stage.sv
module mod3_fix_stage
  import mod3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s2_valid,
  input  lo_t  s2_raw,
  output logic fix_fire,
  output logic out_valid,
  output rem_t out_rem
);

  rem_t rem_next;

  always_comb begin
    rem_next = fold_raw(s2_raw);
    fix_fire = s2_valid && (s2_raw >= lo_t'(MODULUS));
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    out_rem <= rem_next;
  end

endmodule

// File: rtl/mod3_pipe.sv
module mod3_pipe
  import mod3_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_rem
);

  // Internal events brought out by name for the checker.
  logic s1_valid;
  lo_t  s1_qlo;
  lo_t  s1_xlo;
  logic s2_valid;
  lo_t  s2_raw;
  logic fix_fire;

  mod3_recip_stage #(.DATA_W(DATA_W)) u_recip (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .s1_valid (s1_valid),
    .s1_qlo   (s1_qlo),
    .s1_xlo   (s1_xlo)
  );

  mod3_sub_stage u_sub (
    .clk      (clk),
    .rst      (rst),
    .s1_valid (s1_valid),
    .s1_qlo   (s1_qlo),
    .s1_xlo   (s1_xlo),
    .s2_valid (s2_valid),
    .s2_raw   (s2_raw)
  );

  mod3_fix_stage u_fix (
    .clk       (clk),
    .rst       (rst),
    .s2_valid  (s2_valid),
    .s2_raw    (s2_raw),
    .fix_fire  (fix_fire),
    .out_valid (out_valid),
    .out_rem   (out_rem)
  );

endmodule

// File: rtl/mod3_pipe_chk.sv
module mod3_pipe_chk
  import mod3_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       s1_valid,
  input logic       s2_valid,
  input lo_t        s2_raw,
  input logic       fix_fire,
  input logic       out_valid,
  input logic [1:0] out_rem
);

  // Count non-reset edges up to the pipeline depth.
  logic [1:0] since_rst;
  logic       rst_seen;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: three-edge qualifier latency
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3: the remainder code 3 never appears
  p_rem_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rem != 2'd3));

  // R4: the uncorrected difference stays within 0..5
  p_raw_range_r4: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> (s2_raw <= lo_t'(RAW_MAX)));

  // R5: the correction takes off exactly three
  p_fix_sub_r5: assert property (@(posedge clk) disable iff (rst)
    fix_fire |=> (out_rem == 2'($past(s2_raw) - lo_t'(MODULUS))));

  // R5: no correction passes the difference through
  p_fix_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && !fix_fire) |=> (out_rem == 2'($past(s2_raw))));

  // R7: a qualifier moves forward one stage per edge
  p_advance_r7: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> s2_valid);

  // R6: reset leaves every stage empty
  always_ff @(posedge clk) begin
    if (rst_seen) begin
      p_reset_clear_r6: assert (!out_valid && !s2_valid && !s1_valid);
    end
  end

endmodule

bind mod3_pipe mod3_pipe_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .s2_valid  (s2_valid),
  .s2_raw    (s2_raw),
  .fix_fire  (fix_fire),
  .out_valid (out_valid),
  .out_rem   (out_rem)
);

// File: tb/tb_mod3_pipe.sv
module tb_mod3_pipe;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = 16'd0;
  logic        out_valid;
  logic [1:0]  out_rem;

  int chk_n = 0;
  int err_n = 0;
  int cyc   = 0;
  int exp_q[$];
  int due_q[$];
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  mod3_pipe dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_rem   (out_rem)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chk_n++;
    if (!ok) begin
      err_n++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic send(input int x);
    in_valid = 1'b1;
    in_data  = 16'(x);
    exp_q.push_back(x % 3);
    due_q.push_back(cyc + 3);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: scoreboard compare away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected out_valid", 1, 0);
        end else begin
          int e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          check(cyc == d, "R1 latency", cyc, d);
          check(int'(out_rem) == e, "R2 remainder", int'(out_rem), e);
          check(out_rem != 2'd3, "R3 code range", int'(out_rem), e);
        end
      end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
        check(1'b0, "R7 missing result", 0, 1);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 reset state", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: small operands with gaps
    for (int i = 0; i < 7; i++) begin
      send(i);
      idle(i % 3);
    end
    idle(4);

    // R2 R7: every operand, back to back
    for (int i = 0; i < 65536; i++) send(i);
    idle(4);

    // R2 R4: top of range, descending, alternating gaps
    for (int i = 65535; i > 65500; i--) begin
      send(i);
      if (i % 2 == 0) idle(1);
    end
    idle(4);

    // R8: reset raised with operands in flight
    send(65534);
    send(65533);
    rst = 1'b1;
    exp_q.delete();
    due_q.delete();
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 out_valid during reset", int'(out_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(out_valid == 1'b0, "R8 flushed operand appeared", int'(out_valid), 0);
      @(negedge clk);
    end

    // R7: recovery after reset
    send(11);
    send(12);
    send(13);
    idle(6);
    check(exp_q.size() == 0, "R7 results outstanding", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", chk_n, err_n);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk_n++;
      err_n++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", chk_n, err_n);
      $finish;
    end
  end

endmodule